// File: doc/BRIEF.md
# Adjustment Register Bank with Blanking-Synchronized Updates

This block holds the picture-adjustment settings of a display video controller: contrast, brightness, on-screen-display contrast, a gain and a reference-voltage level for each colour channel, and a six-bit control word. A byte-level front end sends it transaction events: a start, the bytes of the transaction one at a time, and a stop. The first byte after a start is a subaddress and the later bytes are data. For every byte the block returns an accept or reject decision, which the front end uses to acknowledge or not acknowledge the byte.

Bit 7 of the subaddress selects how a write is applied. With the bit clear, the data bytes are staged and all of them reach the live registers together when the stop arrives. With the bit set, one byte is parked in a holding slot and written at the next vertical blanking pulse. This keeps user adjustments from tearing a visible picture. While a parked byte waits, the bank refuses all traffic.

Top module: `vadj_regbank`

## Requirements
- R1: While `rst` is high and after it is released, every live register reads 0, except `ctl_o`, which reads 6'b001000 (bit 3 = sync polarity, set).
- R2: The register index is subaddress bits 6:0. The map is 0 contrast, 1 brightness, 2 OSD contrast, 3..5 gain of channels 0..2, 6..8 reference of channels 0..2, and 9 control. A subaddress with index 10 or above is rejected, and so is every data byte that follows it in the same transaction.
- R3: Each byte event produces `ack_valid_o` high for exactly the next cycle. `ack_ok_o` = 1 means accepted. A byte outside a transaction (no start yet, or after a stop) is rejected.
- R4: When subaddress bit 7 = 0 (direct mode), accepted data changes no output before the stop. All of it appears at the clock edge that samples the stop. A new start before a stop discards the staged data. Any number of direct transactions may follow one another, and none of them needs a blanking pulse.
- R5: In direct mode, each further data byte goes to the next index. A data byte whose target index is 10 or above is rejected and stores nothing.
- R6: A register narrower than 8 bits (contrast, brightness and gains: 6, OSD contrast: 4, control: 6) keeps only the low bits of the data byte.
- R7: When subaddress bit 7 = 1 (buffered mode), the first data byte is accepted and held together with its index. The stop changes no output. A buffered transaction with no data byte leaves nothing waiting.
- R8: In buffered mode, the second and later data bytes of a transaction are rejected and do not replace the held byte.
- R9: From the stop of a buffered transaction that holds a byte until that byte is applied, every byte of any new transaction is rejected and its data is ignored.
- R10: `vblank_i` is synchronized through two flops. The held byte is written at the third rising clock edge that samples `vblank_i` high after a low sample. A rising edge that is detected no later than the edge that samples the stop does not apply the byte.
- R11: Asserting `rst` discards a held byte and ends the wait, so a later blanking pulse writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| vblank_i | input | 1 | Vertical blanking pulse, asynchronous |
| ev_start_i | input | 1 | Transaction start event, one cycle |
| ev_stop_i | input | 1 | Transaction stop event, one cycle |
| ev_byte_i | input | 1 | Byte received event, one cycle |
| ev_data_i | input | 8 | Byte value, valid with `ev_byte_i` |
| ack_valid_o | output | 1 | Decision for the previous cycle's byte is present |
| ack_ok_o | output | 1 | 1 = byte accepted, 0 = rejected |
| contrast_o | output | 6 | Live contrast |
| brightness_o | output | 6 | Live brightness |
| osd_con_o | output | 4 | Live OSD contrast |
| gain_o | output | 18 | Live gains, channel n in bits 6n+5:6n |
| vref_o | output | 24 | Live reference levels, channel n in bits 8n+7:8n |
| ctl_o | output | 6 | Live control word |

## Verification
The accept decision for a byte is registered, so it appears one cycle after the byte event. A direct-mode commit becomes visible right after the edge that samples the stop. A buffered commit lands on the third edge that samples `vblank_i` high. The bench's behavioural model advances on each rising edge and is compared with every output on the falling edge, so each result is checked in the cycle it is due. Explicit probes taken one nanosecond after successive edges pin down the two cycles before the blanking commit and the cycle in which it lands.

// File: rtl/vadj_pkg.sv
package vadj_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 7;

    localparam int CON_W  = 6;
    localparam int BRI_W  = 6;
    localparam int OSD_W  = 4;
    localparam int GAIN_W = 6;
    localparam int VREF_W = 8;
    localparam int CTL_W  = 6;

    localparam int CTL_POL_BIT = 3;

    localparam int IDX_CON   = 0;
    localparam int IDX_BRI   = 1;
    localparam int IDX_OSD   = 2;
    localparam int IDX_GAIN0 = 3;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_SUB,
        XS_DATA,
        XS_REJ
    } xact_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] val;
    } wr_t;

    function automatic int idx_vref0(input int nch);
        return IDX_GAIN0 + nch;
    endfunction

    function automatic int idx_ctl(input int nch);
        return IDX_GAIN0 + 2 * nch;
    endfunction

    function automatic int num_regs(input int nch);
        return idx_ctl(nch) + 1;
    endfunction

    function automatic int reg_width(input int i, input int nch);
        if (i == IDX_CON)             return CON_W;
        else if (i == IDX_BRI)        return BRI_W;
        else if (i == IDX_OSD)        return OSD_W;
        else if (i < idx_vref0(nch))  return GAIN_W;
        else if (i < idx_ctl(nch))    return VREF_W;
        else                          return CTL_W;
    endfunction

    function automatic logic [BYTE_W-1:0] reg_reset(input int i, input int nch);
        if (i == idx_ctl(nch)) return BYTE_W'(1 << CTL_POL_BIT);
        else                   return '0;
    endfunction

endpackage

// File: rtl/vadj_vb_edge.sv
module vadj_vb_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/vadj_xact.sv
module vadj_xact
    import vadj_pkg::*;
#(
    parameter int NREG = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start_i,
    input  logic              ev_stop_i,
    input  logic              ev_byte_i,
    input  logic [BYTE_W-1:0] ev_data_i,
    input  logic              vb_rise_i,
    output logic              ack_v_o,
    output logic              ack_ok_o,
    output logic              stage_we_o,
    output logic              stage_clr_o,
    output wr_t               stage_o,
    output logic              commit_dir_o,
    output logic              commit_buf_o,
    output wr_t               hold_o,
    output logic              pend_o
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NREG);

    xact_e            st_q;
    logic             is_buf_q, have_q, pend_q;
    logic [IDX_W-1:0] ptr_q;
    wr_t              hold_q;
    logic             ack_v_q, ack_ok_q;

    logic go_start, go_stop, go_byte, accept, in_data;

    assign go_start = ev_start_i;
    assign go_stop  = ev_stop_i & ~ev_start_i;
    assign go_byte  = ev_byte_i & ~ev_start_i & ~ev_stop_i;
    assign in_data  = (st_q == XS_DATA);

    always_comb begin
        case (st_q)
            XS_SUB:  accept = (ev_data_i[IDX_W-1:0] < LIMIT);
            XS_DATA: accept = is_buf_q ? ~have_q : (ptr_q < LIMIT);
            default: accept = 1'b0;
        endcase
        accept = accept & go_byte;
    end

    assign stage_we_o   = accept & in_data & ~is_buf_q;
    assign stage_clr_o  = go_start;
    assign stage_o      = '{idx: ptr_q, val: ev_data_i};
    assign commit_dir_o = go_stop & in_data & ~is_buf_q;
    assign commit_buf_o = pend_q & vb_rise_i;
    assign hold_o       = hold_q;
    assign pend_o       = pend_q;
    assign ack_v_o      = ack_v_q;
    assign ack_ok_o     = ack_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= XS_IDLE;
            is_buf_q <= 1'b0;
            have_q   <= 1'b0;
            pend_q   <= 1'b0;
            ptr_q    <= '0;
            hold_q   <= '0;
            ack_v_q  <= 1'b0;
            ack_ok_q <= 1'b0;
        end else begin
            ack_v_q  <= go_byte;
            ack_ok_q <= accept;
            if (commit_buf_o) pend_q <= 1'b0;
            if (go_start) begin
                st_q   <= pend_q ? XS_REJ : XS_SUB;
                have_q <= 1'b0;
            end else if (go_stop) begin
                if (in_data && is_buf_q && have_q) pend_q <= 1'b1;
                st_q <= XS_IDLE;
            end else if (go_byte) begin
                if (st_q == XS_SUB) begin
                    if (accept) begin
                        st_q     <= XS_DATA;
                        is_buf_q <= ev_data_i[BYTE_W-1];
                        ptr_q    <= ev_data_i[IDX_W-1:0];
                    end else begin
                        st_q <= XS_REJ;
                    end
                end else if (in_data && accept) begin
                    if (is_buf_q) begin
                        have_q <= 1'b1;
                        hold_q <= '{idx: ptr_q, val: ev_data_i};
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vadj_regfile.sv
module vadj_regfile
    import vadj_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int NREG = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   stage_we_i,
    input  logic                   stage_clr_i,
    input  wr_t                    stage_i,
    input  logic                   commit_dir_i,
    input  logic                   commit_buf_i,
    input  wr_t                    hold_i,
    output logic [NREG*BYTE_W-1:0] live_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int               W   = reg_width(i, NCH);
        localparam logic [BYTE_W-1:0] MSK = BYTE_W'((1 << W) - 1);
        localparam logic [BYTE_W-1:0] RST = reg_reset(i, NCH);
        localparam logic [IDX_W-1:0]  ME  = IDX_W'(i);

        logic [BYTE_W-1:0] shd_q, live_q;
        logic              dirty_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shd_q   <= '0;
                dirty_q <= 1'b0;
                live_q  <= RST;
            end else begin
                if (stage_clr_i) begin
                    dirty_q <= 1'b0;
                end else if (stage_we_i && stage_i.idx == ME) begin
                    shd_q   <= stage_i.val & MSK;
                    dirty_q <= 1'b1;
                end
                if (commit_dir_i && dirty_q)
                    live_q <= shd_q;
                else if (commit_buf_i && hold_i.idx == ME)
                    live_q <= hold_i.val & MSK;
            end
        end

        assign live_o[i*BYTE_W +: BYTE_W] = live_q;
    end
endmodule

// File: rtl/vadj_regbank.sv
module vadj_regbank
    import vadj_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vblank_i,
    input  logic                  ev_start_i,
    input  logic                  ev_stop_i,
    input  logic                  ev_byte_i,
    input  logic [BYTE_W-1:0]     ev_data_i,
    output logic                  ack_valid_o,
    output logic                  ack_ok_o,
    output logic [CON_W-1:0]      contrast_o,
    output logic [BRI_W-1:0]      brightness_o,
    output logic [OSD_W-1:0]      osd_con_o,
    output logic [NCH*GAIN_W-1:0] gain_o,
    output logic [NCH*VREF_W-1:0] vref_o,
    output logic [CTL_W-1:0]      ctl_o
);
    localparam int NREG   = num_regs(NCH);
    localparam int I_VREF = idx_vref0(NCH);
    localparam int I_CTL  = idx_ctl(NCH);

    logic                   vb_rise_w, pend_w;
    logic                   stage_we_w, stage_clr_w, commit_dir_w, commit_buf_w;
    wr_t                    stage_w, hold_w;
    logic [NREG*BYTE_W-1:0] live_w;

    vadj_vb_edge #(.STAGES(SYNC_STAGES)) u_vb (
        .clk     (clk),
        .rst     (rst),
        .async_i (vblank_i),
        .rise_o  (vb_rise_w)
    );

    vadj_xact #(.NREG(NREG)) u_xact (
        .clk          (clk),
        .rst          (rst),
        .ev_start_i   (ev_start_i),
        .ev_stop_i    (ev_stop_i),
        .ev_byte_i    (ev_byte_i),
        .ev_data_i    (ev_data_i),
        .vb_rise_i    (vb_rise_w),
        .ack_v_o      (ack_valid_o),
        .ack_ok_o     (ack_ok_o),
        .stage_we_o   (stage_we_w),
        .stage_clr_o  (stage_clr_w),
        .stage_o      (stage_w),
        .commit_dir_o (commit_dir_w),
        .commit_buf_o (commit_buf_w),
        .hold_o       (hold_w),
        .pend_o       (pend_w)
    );

    vadj_regfile #(.NCH(NCH), .NREG(NREG)) u_rf (
        .clk          (clk),
        .rst          (rst),
        .stage_we_i   (stage_we_w),
        .stage_clr_i  (stage_clr_w),
        .stage_i      (stage_w),
        .commit_dir_i (commit_dir_w),
        .commit_buf_i (commit_buf_w),
        .hold_i       (hold_w),
        .live_o       (live_w)
    );

    assign contrast_o   = live_w[IDX_CON*BYTE_W +: CON_W];
    assign brightness_o = live_w[IDX_BRI*BYTE_W +: BRI_W];
    assign osd_con_o    = live_w[IDX_OSD*BYTE_W +: OSD_W];
    assign ctl_o        = live_w[I_CTL*BYTE_W +: CTL_W];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign gain_o[c*GAIN_W +: GAIN_W] = live_w[(IDX_GAIN0 + c)*BYTE_W +: GAIN_W];
        assign vref_o[c*VREF_W +: VREF_W] = live_w[(I_VREF + c)*BYTE_W +: VREF_W];
    end
endmodule

// File: rtl/vadj_regbank_chk.sv
module vadj_regbank_chk #(
    parameter int NREG = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_start_i,
    input logic              ev_stop_i,
    input logic              ev_byte_i,
    input logic              ack_valid_o,
    input logic              ack_ok_o,
    input logic              pend,
    input logic              vb_rise,
    input logic [NREG*8-1:0] live,
    input logic [5:0]        ctl_o
);
    // R1: reset values are present after every reset cycle
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (ctl_o == 6'b001000 && live[(NREG-1)*8-1:0] == '0 &&
                 live[NREG*8-1 -: 8] == 8'h08));

    // R3: a decision appears exactly one cycle after each byte event
    p_ack_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_byte_i && !ev_start_i && !ev_stop_i) |=> ack_valid_o);

    p_no_stray_ack_r3: assert property (@(posedge clk) disable iff (rst)
        ack_valid_o |-> $past(ev_byte_i));

    // R9: bytes are refused while a held byte waits
    p_pend_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_byte_i && !ev_start_i && !ev_stop_i && pend) |=> (ack_valid_o && !ack_ok_o));

    // R10: the wait ends only on a detected blanking edge
    p_wait_until_edge_r10: assert property (@(posedge clk) disable iff (rst)
        (pend && !vb_rise) |=> pend);

    // R4: the live registers move only on a stop or on a blanking commit
    p_live_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!ev_stop_i && !(pend && vb_rise)) |=> $stable(live));

    // R11: reset ends any wait
    p_reset_cancel_r11: assert property (@(posedge clk)
        rst |=> !pend);
endmodule

bind vadj_regbank vadj_regbank_chk #(.NREG(NREG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_start_i  (ev_start_i),
    .ev_stop_i   (ev_stop_i),
    .ev_byte_i   (ev_byte_i),
    .ack_valid_o (ack_valid_o),
    .ack_ok_o    (ack_ok_o),
    .pend        (pend_w),
    .vb_rise     (vb_rise_w),
    .live        (live_w),
    .ctl_o       (ctl_o)
);

// File: tb/sim_vadj_regbank.sv
`timescale 1ns/1ps
module sim_vadj_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vblank_i = 1'b0;
    logic        ev_start_i = 1'b0, ev_stop_i = 1'b0, ev_byte_i = 1'b0;
    logic [7:0]  ev_data_i = 8'h00;
    logic        ack_valid_o, ack_ok_o;
    logic [5:0]  contrast_o, brightness_o, ctl_o;
    logic [3:0]  osd_con_o;
    logic [17:0] gain_o;
    logic [23:0] vref_o;

    always #2.5 clk = ~clk;

    vadj_regbank u0 (
        .clk(clk), .rst(rst), .vblank_i(vblank_i),
        .ev_start_i(ev_start_i), .ev_stop_i(ev_stop_i), .ev_byte_i(ev_byte_i),
        .ev_data_i(ev_data_i), .ack_valid_o(ack_valid_o), .ack_ok_o(ack_ok_o),
        .contrast_o(contrast_o), .brightness_o(brightness_o), .osd_con_o(osd_con_o),
        .gain_o(gain_o), .vref_o(vref_o), .ctl_o(ctl_o)
    );

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // widths per index from R2/R6
    function automatic int wmask(input int i);
        case (i)
            2:       return 'h0f;
            6, 7, 8: return 'hff;
            default: return 'h3f;
        endcase
    endfunction

    function automatic int dut_reg(input int i);
        case (i)
            0:       return int'(contrast_o);
            1:       return int'(brightness_o);
            2:       return int'(osd_con_o);
            3, 4, 5: return int'(gain_o >> (6 * (i - 3))) & 'h3f;
            6, 7, 8: return int'(vref_o >> (8 * (i - 6))) & 'hff;
            default: return int'(ctl_o);
        endcase
    endfunction

    // behavioural reference model
    int m_reg[10], m_stage[10];
    bit m_dirty[10];
    int m_vb[3];
    bit m_in, m_sub, m_bad, m_buf, m_have, m_pend, m_ackv, m_acko;
    int m_ptr, m_hidx, m_hval;

    always @(posedge clk) begin
        bit pend_old, rise, ok;
        if (rst) begin
            foreach (m_reg[i]) begin m_reg[i] = 0; m_dirty[i] = 0; end
            m_reg[9] = 'h08;
            foreach (m_vb[i]) m_vb[i] = 0;
            m_in = 0; m_sub = 0; m_bad = 0; m_buf = 0; m_have = 0; m_pend = 0;
            m_ackv = 0; m_acko = 0; m_ptr = 0;
        end else begin
            pend_old = m_pend;
            rise = (m_vb[1] == 1 && m_vb[2] == 0);
            if (pend_old && rise) begin
                m_reg[m_hidx] = m_hval & wmask(m_hidx);
                m_pend = 0;
            end
            m_vb[2] = m_vb[1]; m_vb[1] = m_vb[0]; m_vb[0] = int'(vblank_i);
            m_ackv = 0; m_acko = 0;
            if (ev_start_i) begin
                m_in = 1; m_sub = 0; m_bad = pend_old; m_have = 0;
                foreach (m_dirty[i]) m_dirty[i] = 0;
            end else if (ev_stop_i) begin
                if (m_in && m_sub && !m_bad) begin
                    if (m_buf) begin
                        if (m_have) m_pend = 1;
                    end else begin
                        foreach (m_reg[i]) if (m_dirty[i]) m_reg[i] = m_stage[i];
                    end
                end
                m_in = 0;
            end else if (ev_byte_i) begin
                ok = 0;
                if (m_in && !m_bad) begin
                    if (!m_sub) begin
                        m_sub = 1;
                        m_buf = ev_data_i[7];
                        m_ptr = int'(ev_data_i[6:0]);
                        if (m_ptr >= 10) m_bad = 1; else ok = 1;
                    end else if (m_buf) begin
                        if (!m_have) begin
                            ok = 1; m_have = 1; m_hidx = m_ptr; m_hval = int'(ev_data_i);
                        end
                    end else if (m_ptr < 10) begin
                        ok = 1;
                        m_stage[m_ptr] = int'(ev_data_i) & wmask(m_ptr);
                        m_dirty[m_ptr] = 1;
                        m_ptr++;
                    end
                end
                m_ackv = 1; m_acko = ok;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({cur_req, " ack_valid"}, int'(ack_valid_o), int'(m_ackv));
            chk({cur_req, " ack_ok"}, int'(ack_ok_o), int'(m_acko));
            for (int i = 0; i < 10; i++) chk({cur_req, " reg"}, dut_reg(i), m_reg[i]);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask
    task automatic do_start();
        ev_start_i = 1; tick(); ev_start_i = 0;
    endtask
    task automatic do_stop();
        ev_stop_i = 1; tick(); ev_stop_i = 0;
    endtask
    task automatic do_byte(input logic [7:0] d);
        ev_byte_i = 1; ev_data_i = d; tick(); ev_byte_i = 0;
    endtask
    task automatic vb_pulse();
        vblank_i = 1; repeat (4) tick(); vblank_i = 0; repeat (3) tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset values
        for (int i = 0; i < 9; i++) chk("R1", dut_reg(i), 0);
        chk("R1", int'(ctl_o), 'h08);

        // R3 byte outside a transaction
        cur_req = "R3";
        do_byte(8'h00); tick();
        chk("R3", int'(ack_ok_o), 0);

        // R4 direct single write
        cur_req = "R4";
        do_start(); do_byte(8'h00); do_byte(8'h15);
        chk("R4 before stop", int'(contrast_o), 0);
        do_stop();
        chk("R4 after stop", int'(contrast_o), 'h15);
        do_start(); do_byte(8'h01); do_byte(8'h2A); do_start(); do_stop();
        chk("R4 discarded", int'(brightness_o), 0);

        // R5 auto-increment across gains and into references
        cur_req = "R5";
        do_start(); do_byte(8'h03);
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33); do_byte(8'hC4);
        do_stop();
        chk("R5 vref0", int'(vref_o[7:0]), 'hC4);
        do_start(); do_byte(8'h08); do_byte(8'h5A); do_byte(8'h3F); do_byte(8'h77); tick();
        chk("R5 past end", int'(ack_ok_o), 0);
        do_stop();
        chk("R5 ctl", int'(ctl_o), 'h3F);

        // R6 narrow register
        cur_req = "R6";
        do_start(); do_byte(8'h02); do_byte(8'hFF); do_stop();
        chk("R6 osd", int'(osd_con_o), 'hF);

        // R2 unused subaddress
        cur_req = "R2";
        do_start(); do_byte(8'h0C); do_byte(8'h01); do_stop();
        do_start(); do_byte(8'h8A); do_byte(8'h01); do_stop();
        repeat (2) tick();

        // R7 / R8 buffered write
        cur_req = "R7";
        do_start(); do_byte(8'h81); do_byte(8'h33);
        cur_req = "R8";
        do_byte(8'h22); tick();
        chk("R8 second byte", int'(ack_ok_o), 0);
        cur_req = "R7";
        do_stop();
        chk("R7 held", int'(brightness_o), 0);

        // R9 reject while waiting
        cur_req = "R9";
        do_start(); do_byte(8'h00); do_byte(8'h01); do_stop();
        chk("R9 ignored", int'(contrast_o), 'h15);

        // R10 commit timing
        cur_req = "R10";
        vblank_i = 1;
        tick(); chk("R10 edge1", int'(brightness_o), 0);
        tick(); chk("R10 edge2", int'(brightness_o), 0);
        tick(); chk("R10 edge3", int'(brightness_o), 'h33);
        repeat (2) tick(); vblank_i = 0; repeat (3) tick();

        // R10 edge before stop does not count
        do_start(); do_byte(8'h86); do_byte(8'h5A);
        vblank_i = 1; repeat (4) tick();
        do_stop(); repeat (3) tick();
        chk("R10 early edge", int'(vref_o[7:0]), 'hC4);
        vblank_i = 0; repeat (3) tick();
        vb_pulse();
        chk("R10 late edge", int'(vref_o[7:0]), 'h5A);

        // R7 subaddress only leaves nothing waiting
        cur_req = "R7";
        do_start(); do_byte(8'h82); do_stop();
        do_start(); do_byte(8'h02); do_byte(8'h06); do_stop();
        chk("R7 no wait", int'(osd_con_o), 6);

        // R11 reset cancels a waiting byte
        cur_req = "R11";
        do_start(); do_byte(8'h81); do_byte(8'h2C); do_stop();
        rst = 1; repeat (2) tick(); rst = 0; tick();
        vb_pulse();
        chk("R11 brightness", int'(brightness_o), 0);
        chk("R11 ctl", int'(ctl_o), 'h08);

        repeat (3) tick();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule